// File: doc/BRIEF.md
# Coarse Frequency Search Controller

This block is the digital coarse-tuning loop of a dual-loop clock recovery system. A frequency detector feeds two window comparators. One fires when the filtered detector level rises above a high threshold, the other when it falls below a low threshold. The controller samples both comparator flags through a two-flop synchroniser. After a start request it sweeps an 8-bit coarse tuning code upward. The code moves by one step every `DWELL` clock cycles so that the analog filter can settle after each step.

While the oscillator is far from the data rate, the detector output averages to about zero and neither flag fires, so the sweep goes on. Near lock the detector carries a DC level, and one of the flags stays asserted. Once either flag has been high for `PERSIST` consecutive synchronised samples, the controller freezes the code and reports lock. The fine loop then handles the remaining error. A sweep that reaches the top code without locking wraps to zero and marks the wrap with a one-cycle pulse.

The code drives a capacitor bank in two parts. The upper nibble goes out as a 15-bit thermometer vector for the segmented section. The lower nibble goes out unchanged for the binary-weighted section.

The sequencer has three states:
- `ST_IDLE` is the state after reset.
- `ST_SEARCH` is the sweep.
- `ST_LOCKED` holds the frozen code.

Its transitions:
- IDLE→SEARCH on start.
- SEARCH→SEARCH on start (restart from zero).
- SEARCH→LOCKED on a qualified trip.
- LOCKED→SEARCH on start.

Every other state stays where it is.

Top module: `coarse_search_ctrl`

## Requirements
- R1: After reset the code is 0, `locked_o` and `sweep_done_o` are 0, and the code does not move until `start_i` is sampled high.
- R2: When `start_i` is sampled high at edge S, the code is 0 after edge S. While searching, the code after edge S+k equals floor(k/DWELL) modulo 256.
- R3: Suppose either comparator input (`fd_hi_i` or `fd_lo_i`, each alone being enough) is high from the edge F onward. Then `locked_o` is still 0 after edge F+PERSIST+1 and is 1 after edge F+PERSIST+2. The frozen code is the value the code held after edge F+PERSIST+1.
- R4: A flag run shorter than PERSIST consecutive samples neither locks the block nor halts the sweep.
- R5: While locked with `start_i` low, the code and `locked_o` stay constant even after both flags fall.
- R6: Stepping up from code 255 gives code 0, and `sweep_done_o` is high for exactly the one cycle after that edge. The search continues.
- R7: Bit k of `therm_o` is 1 exactly when `code_o[7:4]` is greater than k, for k = 0..14. `bin_o` equals `code_o[3:0]`.
- R8: A start sampled while locked clears `locked_o` and restarts the sweep from code 0 with the timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Restart the search from code 0 |
| fd_hi_i | input | 1 | Comparator flag: detector level above high threshold (asynchronous) |
| fd_lo_i | input | 1 | Comparator flag: detector level below low threshold (asynchronous) |
| code_o | output | 8 | Coarse tuning code |
| therm_o | output | 15 | Thermometer decode of the upper nibble |
| bin_o | output | 4 | Lower nibble for the binary-weighted section |
| locked_o | output | 1 | High while the code is frozen |
| sweep_done_o | output | 1 | One-cycle pulse when the code wraps from 255 to 0 |

## Verification
A full undisturbed sweep visits all 256 codes once per dwell window. It checks the step timing, both encoded fields for every nibble value, and the wrap pulse with its single-cycle width.

Lock is tried with flags raised at some two dozen offsets after start, alternating between the high and the low comparator. Each trial checks the exact cycle in which lock appears and the frozen code, which separates a correct persistence count and synchroniser depth from ones that are off by one. Each trial also checks that the code holds once the flags drop, and that start restarts the sweep from a locked state.

A flag burst one sample shorter than the persistence limit shows that short bursts are filtered rather than treated as lock.

// File: rtl/css_pkg.sv
package css_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LOCKED = 2'd2
    } css_state_e;
endpackage

// File: rtl/css_flag_qual.sv
// Synchronises the two window-comparator flags and qualifies a trip once
// either has been high for PERSIST consecutive synchronised samples.
module css_flag_qual #(
    parameter int PERSIST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic hi_i,
    input  logic lo_i,
    output logic trip_o
);
    localparam int RUN_W = $clog2(PERSIST + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PERSIST);

    logic [1:0]       meta_q;
    logic [1:0]       sync_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            run_q  <= '0;
        end else begin
            meta_q <= {hi_i, lo_i};
            sync_q <= meta_q;
            if (clr_i)
                run_q <= '0;
            else if (|sync_q)
                run_q <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
            else
                run_q <= '0;
        end
    end

    assign trip_o = (run_q == RUN_MAX);

    AST_RUN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX); // R4

    AST_TRIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> $past(|sync_q)); // R3
endmodule

// File: rtl/css_sequencer.sv
// Search state machine with dwell timer and coarse code counter.
module css_sequencer
    import css_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int DWELL  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              trip_i,
    output logic [CODE_W-1:0] code_o,
    output logic              locked_o,
    output logic              sweep_done_o
);
    localparam int DW_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [DW_W-1:0]   DW_LAST  = DW_W'(DWELL - 1);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    css_state_e        st_q, st_d;
    logic [DW_W-1:0]   dwell_q;
    logic [CODE_W-1:0] code_q;
    logic              done_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_i) st_d = ST_SEARCH;
            ST_SEARCH: begin
                if (start_i)     st_d = ST_SEARCH;
                else if (trip_i) st_d = ST_LOCKED;
            end
            ST_LOCKED: if (start_i) st_d = ST_SEARCH;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs: dwell timer, code counter, wrap pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell_q <= '0;
            code_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                dwell_q <= '0;
                code_q  <= '0;
            end else if (st_q == ST_SEARCH && !trip_i) begin
                if (dwell_q == DW_LAST) begin
                    dwell_q <= '0;
                    code_q  <= code_q + 1'b1;
                    done_q  <= (code_q == CODE_MAX);
                end else begin
                    dwell_q <= dwell_q + 1'b1;
                end
            end
        end
    end

    assign code_o       = code_q;
    assign locked_o     = (st_q == ST_LOCKED);
    assign sweep_done_o = done_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !start_i) |=> (code_q == '0)); // R1

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEARCH && !start_i && code_q != CODE_MAX)
        |=> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1)); // R2

    AST_LOCK_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(trip_i)); // R3

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !start_i) |=> ($stable(code_q) && locked_o)); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done_o |=> !sweep_done_o); // R6

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done_o |-> (code_q == '0)); // R6
endmodule

// File: rtl/css_code_enc.sv
// Splits the coarse code into a thermometer upper field and a binary lower field.
module css_code_enc #(
    parameter int CODE_W = 8,
    parameter int SEG_W  = 4
) (
    input  logic [CODE_W-1:0]       code_i,
    output logic [(2**SEG_W)-2:0]   therm_o,
    output logic [CODE_W-SEG_W-1:0] bin_o
);
    localparam int BIN_W = CODE_W - SEG_W;
    localparam int SEG_N = (2**SEG_W) - 1;

    logic [SEG_W-1:0] seg;
    assign seg   = code_i[CODE_W-1:BIN_W];
    assign bin_o = code_i[BIN_W-1:0];

    for (genvar k = 0; k < SEG_N; k++) begin : g_therm
        assign therm_o[k] = (seg > SEG_W'(k));
    end
endmodule

// File: rtl/coarse_search_ctrl.sv
module coarse_search_ctrl #(
    parameter int CODE_W  = 8,
    parameter int SEG_W   = 4,
    parameter int DWELL   = 16,
    parameter int PERSIST = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    fd_hi_i,
    input  logic                    fd_lo_i,
    output logic [CODE_W-1:0]       code_o,
    output logic [(2**SEG_W)-2:0]   therm_o,
    output logic [CODE_W-SEG_W-1:0] bin_o,
    output logic                    locked_o,
    output logic                    sweep_done_o
);
    localparam int BIN_W = CODE_W - SEG_W;

    logic trip;

    css_flag_qual #(.PERSIST(PERSIST)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .hi_i   (fd_hi_i),
        .lo_i   (fd_lo_i),
        .trip_o (trip)
    );

    css_sequencer #(.CODE_W(CODE_W), .DWELL(DWELL)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .trip_i       (trip),
        .code_o       (code_o),
        .locked_o     (locked_o),
        .sweep_done_o (sweep_done_o)
    );

    css_code_enc #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_enc (
        .code_i  (code_o),
        .therm_o (therm_o),
        .bin_o   (bin_o)
    );

    AST_THERM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(therm_o) == int'(code_o[CODE_W-1:BIN_W])); // R7

    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm_o + 1'b1) & therm_o) == '0); // R7
endmodule

// File: tb/sim_coarse_search_ctrl.sv
module sim_coarse_search_ctrl;
    localparam int CLK_T = 10;
    localparam int D     = 16;
    localparam int P     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        fd_hi_i = 1'b0;
    logic        fd_lo_i = 1'b0;
    logic [7:0]  code_o;
    logic [14:0] therm_o;
    logic [3:0]  bin_o;
    logic        locked_o;
    logic        sweep_done_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_T/2) clk = ~clk;

    coarse_search_ctrl #(.CODE_W(8), .SEG_W(4), .DWELL(D), .PERSIST(P)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .fd_hi_i(fd_hi_i), .fd_lo_i(fd_lo_i),
        .code_o(code_o), .therm_o(therm_o), .bin_o(bin_o),
        .locked_o(locked_o), .sweep_done_o(sweep_done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // one negedge after this task the start edge S has passed (at S+0.5)
    task automatic do_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    initial begin
        #(CLK_T * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int frozen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(code_o == 0, "R1 reset code", code_o, 0);
        chk(locked_o == 0, "R1 reset locked", locked_o, 0);
        chk(sweep_done_o == 0, "R1 reset sweep_done", sweep_done_o, 0);
        repeat (40) @(negedge clk);
        chk(code_o == 0, "R1 idle no step", code_o, 0);

        // full sweep: every code, both fields, and the wrap
        do_start();
        chk(code_o == 0, "R2 code after start", code_o, 0);
        repeat (D/2) @(negedge clk);
        for (int m = 0; m < 256; m++) begin
            int up;
            up = m >> 4;
            chk(code_o == m, "R2 sweep code", code_o, m);
            chk(int'(therm_o) == ((1 << up) - 1), "R7 therm", therm_o, (1 << up) - 1);
            chk(int'(bin_o) == (m & 15), "R7 bin", bin_o, m & 15);
            chk(sweep_done_o == 0, "R6 no early pulse", sweep_done_o, 0);
            if (m != 255) repeat (D) @(negedge clk);
        end
        repeat (D/2 - 1) @(negedge clk);
        chk(code_o == 255 && sweep_done_o == 0, "R6 before wrap", code_o, 255);
        @(negedge clk);
        chk(code_o == 0, "R6 wrapped code", code_o, 0);
        chk(sweep_done_o == 1, "R6 pulse high", sweep_done_o, 1);
        @(negedge clk);
        chk(sweep_done_o == 0, "R6 pulse one cycle", sweep_done_o, 0);
        chk(locked_o == 0, "R6 still searching", locked_o, 0);
        repeat (D) @(negedge clk);
        chk(code_o == 1, "R6 search continues", code_o, 1);

        // short burst: P-1 samples must not lock
        do_start();
        fd_hi_i = 1'b1;
        repeat (P - 1) @(negedge clk);
        fd_hi_i = 1'b0;
        repeat (3 * D - P + 1) @(negedge clk);
        // now at S + 3D + 0.5
        chk(locked_o == 0, "R4 short burst no lock", locked_o, 0);
        chk(code_o == 3, "R4 sweep not halted", code_o, 3);

        // lock at many offsets, alternating comparator
        for (int j = 0; j < 70; j += 3) begin
            int exp_code;
            fd_hi_i = 1'b0;
            fd_lo_i = 1'b0;
            repeat (6) @(negedge clk);
            do_start();
            chk(locked_o == 0, "R8 restart clears lock", locked_o, 0);
            chk(code_o == 0, "R8 restart code zero", code_o, 0);
            repeat (j) @(negedge clk);
            if ((j / 3) % 2 == 0) fd_hi_i = 1'b1;
            else                  fd_lo_i = 1'b1;
            exp_code = (j + 2 + P) / D;
            repeat (P + 2) @(negedge clk);
            chk(locked_o == 0, "R3 not yet locked", locked_o, 0);
            @(negedge clk);
            chk(locked_o == 1, "R3 locked on time", locked_o, 1);
            chk(code_o == exp_code, "R3 frozen code", code_o, exp_code);
            fd_hi_i = 1'b0;
            fd_lo_i = 1'b0;
            repeat (2 * D) @(negedge clk);
            chk(locked_o == 1, "R5 lock held", locked_o, 1);
            chk(code_o == exp_code, "R5 code held", code_o, exp_code);
        end

        // restart from locked follows step timing
        do_start();
        repeat (D) @(negedge clk);
        chk(code_o == 1 && locked_o == 0, "R8 sweep resumes", code_o, 1);

        summary();
        $finish;
    end
endmodule